// File: doc/BRIEF.md
# ADC Software Trigger and Suspend Controller

This block is a 32-bit control and status word that sits in front of a shared analog-to-digital converter. It turns software writes into conversion requests. A one-shot request converts a single selected input. Two global software triggers are available: a one-cycle pulse and a held level. The block also passes through a hardware trigger, drives a manual sample override, and divides the ADC clock into a control-clock enable.

Reconfiguring the converter safely uses a hold handshake. Software sets the trigger-hold bit, and from then on no trigger of any kind may start a conversion. Conversions already in flight still finish. When the hold is in force and every converter reports idle, hardware raises an update-ready flag. If the interrupt enable is set, the rising edge of that flag produces a one-cycle interrupt pulse. All logic runs on the ADC clock, so "next cycle" means the next edge of `clk`.

Top module: `adc_swtrig_ctrl`

## Requirements
- R1: After synchronous reset every bit of the read word is 0, and conv_req, gsw_pulse, gsw_level, hw_trig_fire, sample_force and upd_irq are 0.
- R2: A write updates only the bytes whose byte enable is set (be[0] bits 7:0, be[1] bits 15:8, be[2] bits 23:16, be[3] bits 31:24). The read word holds clock source in 31:30, control divider in 29:24, digital enable in 23, zero in 22:16, reference select in 15:13, trigger hold in 12, update-ready interrupt enable in 11, update-ready in 10, manual sample in 9, single request in 8, global level trigger in 7, global pulse trigger in 6 and input select in 5:0.
- R3: Writing 1 to bit 8 sets the single-request bit for exactly the cycle after the write. In that cycle conv_req is 1 and conv_idx equals bits 5:0. Afterwards the bit reads 0 unless it is written again.
- R4: Writing 1 to bit 6 gives gsw_pulse for exactly one cycle, and the bit then clears itself. Bit 7 drives gsw_level and stays set until software writes it to 0.
- R5: While trigger hold (bit 12) is 1, conv_req, gsw_pulse, gsw_level and hw_trig_fire are all 0. A request written while the hold is set is dropped, and its bit still self-clears.
- R6: Update-ready (bit 10) reads 1 one cycle after a cycle in which the hold is 1 and every conv_busy bit is 0. Otherwise it reads 0. The value written to bit 10 has no effect.
- R7: When bit 11 is 1, upd_irq pulses for one cycle in the cycle where update-ready turns from 0 to 1. When bit 11 is 0, upd_irq stays 0.
- R8: sample_force follows bit 9 and does not clear itself.
- R9: With divider value n in bits 29:24, ctl_clk_en is 1 in one cycle out of every n+1. A value of 0 makes it 1 in every cycle.
- R10: While digital enable (bit 23) is 0, every trigger output is 0, and the request and pulse bits still self-clear.
- R11: An input select of 63 (the reserved code) never produces conv_req. The request bit still clears itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ADC clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_be | input | 4 | Byte enables for the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (current register view) |
| conv_busy | input | NUM_CONV | One bit per converter, 1 while a conversion is running |
| hw_trig_req | input | 1 | Hardware trigger request |
| conv_req | output | 1 | Single-input conversion request pulse |
| conv_idx | output | 6 | Input index that goes with conv_req |
| gsw_pulse | output | 1 | Global software trigger, pulse form |
| gsw_level | output | 1 | Global software trigger, level form |
| hw_trig_fire | output | 1 | Hardware trigger after hold and enable gating |
| sample_force | output | 1 | Keep sample-and-hold in sample mode |
| ctl_clk_en | output | 1 | Divided control-clock enable |
| upd_irq | output | 1 | Update-ready interrupt pulse |

## Verification
A corrupted self-clearing bit shows up within one cycle. It appears either as a request or pulse that lasts a second cycle, or as bit 8 or bit 6 still set in the read word. A wrong hold or enable state leaks a trigger at the ports in the same cycle that a request, pulse or hardware trigger arrives. Update-ready and interrupt faults appear one cycle after the hold and idle condition changes. A prescaler count fault moves the ctl_clk_en spacing within n+1 cycles. The reference model compares every output and the whole read word at every clock, so each of these faults is reported in the cycle where it first shows.

// File: rtl/adcsw_pkg.sv
package adcsw_pkg;

    localparam int SEL_W = 6;
    localparam int DIV_W = 6;

    typedef struct packed {
        logic [1:0]       clk_src;
        logic [DIV_W-1:0] clk_div;
        logic             dig_en;
        logic [2:0]       vref_sel;
        logic             trig_hold;
        logic             upd_ien;
        logic             samp_force;
        logic             req_one;
        logic             gl_level;
        logic             gl_pulse;
        logic [SEL_W-1:0] in_sel;
    } ctl_fields_t;

    // Assemble the read view; update-ready is inserted from the monitor.
    function automatic logic [31:0] pack_view(ctl_fields_t f, logic upd);
        return {f.clk_src, f.clk_div, f.dig_en, 7'd0, f.vref_sel, f.trig_hold,
                f.upd_ien, upd, f.samp_force, f.req_one, f.gl_level, f.gl_pulse,
                f.in_sel};
    endfunction

    // Next field state: self-clearing bits drop first, then the write lands.
    function automatic ctl_fields_t apply_write(ctl_fields_t cur, logic we,
                                                logic [3:0] be, logic [31:0] wd);
        ctl_fields_t n;
        n          = cur;
        n.req_one  = 1'b0;
        n.gl_pulse = 1'b0;
        if (we) begin
            if (be[3]) begin
                n.clk_src = wd[31:30];
                n.clk_div = wd[29:24];
            end
            if (be[2]) n.dig_en = wd[23];
            if (be[1]) begin
                n.vref_sel   = wd[15:13];
                n.trig_hold  = wd[12];
                n.upd_ien    = wd[11];
                n.samp_force = wd[9];
                n.req_one    = wd[8];
            end
            if (be[0]) begin
                n.gl_level = wd[7];
                n.gl_pulse = wd[6];
                n.in_sel   = wd[5:0];
            end
        end
        return n;
    endfunction

endpackage

// File: rtl/adcsw_regfile.sv
module adcsw_regfile
    import adcsw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [3:0]  be,
    input  logic [31:0] wd,
    output ctl_fields_t fields
);
    ctl_fields_t nxt;

    always_comb nxt = apply_write(fields, we, be, wd);

    always_ff @(posedge clk) begin
        if (rst) fields <= '0;
        else     fields <= nxt;
    end

    assert_req_selfclear_R3: assert property (@(posedge clk) disable iff (rst)
        (fields.req_one && !(we && be[1] && wd[8])) |=> !fields.req_one);

    assert_pulse_selfclear_R4: assert property (@(posedge clk) disable iff (rst)
        (fields.gl_pulse && !(we && be[0] && wd[6])) |=> !fields.gl_pulse);

    assert_level_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (fields.gl_level && !(we && be[0])) |=> fields.gl_level);

    assert_samp_holds_R8: assert property (@(posedge clk) disable iff (rst)
        (fields.samp_force && !(we && be[1])) |=> fields.samp_force);

endmodule

// File: rtl/adcsw_prescale.sv
module adcsw_prescale #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    // Comparing with >= lets a shrinking divider recover in one cycle.
    assign tick = (cnt >= div);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    assert_tick_spacing_R9: assert property (@(posedge clk) disable iff (rst)
        (tick && div != '0) |=> (!tick || div == '0));

endmodule

// File: rtl/adcsw_updmon.sv
module adcsw_updmon #(
    parameter int NUM_CONV = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                hold,
    input  logic                ien,
    input  logic [NUM_CONV-1:0] busy,
    output logic                upd,
    output logic                irq
);
    logic upd_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            upd   <= 1'b0;
            upd_d <= 1'b0;
        end else begin
            upd   <= hold && !(|busy);
            upd_d <= upd;
        end
    end

    assign irq = upd && !upd_d && ien;

    assert_upd_needs_hold_R6: assert property (@(posedge clk) disable iff (rst)
        upd |-> $past(hold));

    assert_upd_needs_idle_R6: assert property (@(posedge clk) disable iff (rst)
        upd |-> $past(busy) == '0);

    assert_irq_single_R7: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

endmodule

// File: rtl/adcsw_gate.sv
module adcsw_gate
    import adcsw_pkg::*;
(
    input  ctl_fields_t      fields,
    input  logic             hw_req,
    output logic             conv_req,
    output logic [SEL_W-1:0] conv_idx,
    output logic             gsw_pulse,
    output logic             gsw_level,
    output logic             hw_fire
);
    localparam logic [SEL_W-1:0] RSV_CODE = {SEL_W{1'b1}};

    logic open_q;

    assign open_q    = fields.dig_en && !fields.trig_hold;
    assign conv_req  = open_q && fields.req_one && (fields.in_sel != RSV_CODE);
    assign conv_idx  = fields.in_sel;
    assign gsw_pulse = open_q && fields.gl_pulse;
    assign gsw_level = open_q && fields.gl_level;
    assign hw_fire   = open_q && hw_req;

endmodule

// File: rtl/adc_swtrig_ctrl.sv
module adc_swtrig_ctrl
    import adcsw_pkg::*;
#(
    parameter int NUM_CONV = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_we,
    input  logic [3:0]          reg_be,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic [NUM_CONV-1:0] conv_busy,
    input  logic                hw_trig_req,
    output logic                conv_req,
    output logic [SEL_W-1:0]    conv_idx,
    output logic                gsw_pulse,
    output logic                gsw_level,
    output logic                hw_trig_fire,
    output logic                sample_force,
    output logic                ctl_clk_en,
    output logic                upd_irq
);
    ctl_fields_t fields;
    logic        upd;

    adcsw_regfile u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (reg_we),
        .be     (reg_be),
        .wd     (reg_wdata),
        .fields (fields)
    );

    adcsw_gate u_gate (
        .fields    (fields),
        .hw_req    (hw_trig_req),
        .conv_req  (conv_req),
        .conv_idx  (conv_idx),
        .gsw_pulse (gsw_pulse),
        .gsw_level (gsw_level),
        .hw_fire   (hw_trig_fire)
    );

    adcsw_prescale #(.DIV_W(DIV_W)) u_div (
        .clk  (clk),
        .rst  (rst),
        .div  (fields.clk_div),
        .tick (ctl_clk_en)
    );

    adcsw_updmon #(.NUM_CONV(NUM_CONV)) u_upd (
        .clk  (clk),
        .rst  (rst),
        .hold (fields.trig_hold),
        .ien  (fields.upd_ien),
        .busy (conv_busy),
        .upd  (upd),
        .irq  (upd_irq)
    );

    assign sample_force = fields.samp_force;
    assign reg_rdata    = pack_view(fields, upd);

    assert_hold_blocks_R5: assert property (@(posedge clk) disable iff (rst)
        fields.trig_hold |-> !(conv_req || gsw_pulse || gsw_level || hw_trig_fire));

    assert_disable_blocks_R10: assert property (@(posedge clk) disable iff (rst)
        !fields.dig_en |-> !(conv_req || gsw_pulse || gsw_level || hw_trig_fire));

    assert_no_reserved_R11: assert property (@(posedge clk) disable iff (rst)
        conv_req |-> conv_idx != {SEL_W{1'b1}});

    assert_irq_on_ready_R7: assert property (@(posedge clk) disable iff (rst)
        upd_irq |-> (reg_rdata[10] && reg_rdata[11]));

endmodule

// File: tb/adc_swtrig_ctrl_bench.sv
module adc_swtrig_ctrl_bench;

    localparam int NC = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we  = 1'b0;
    logic [3:0]  be  = '0;
    logic [31:0] wd  = '0;
    logic [31:0] rdata;
    logic [NC-1:0] busy = '0;
    logic        hw_in = 1'b0;
    logic        conv_req, gsw_pulse, gsw_level, hw_fire, samp, ctl_en, irq;
    logic [5:0]  conv_idx;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit live = 0;

    always #4 clk = ~clk;

    adc_swtrig_ctrl #(.NUM_CONV(NC)) u_adc_swtrig_ctrl (
        .clk(clk), .rst(rst), .reg_we(we), .reg_be(be), .reg_wdata(wd),
        .reg_rdata(rdata), .conv_busy(busy), .hw_trig_req(hw_in),
        .conv_req(conv_req), .conv_idx(conv_idx), .gsw_pulse(gsw_pulse),
        .gsw_level(gsw_level), .hw_trig_fire(hw_fire), .sample_force(samp),
        .ctl_clk_en(ctl_en), .upd_irq(irq)
    );

    // Behavioural reference model
    int m_src, m_div, m_den, m_vref, m_hold, m_ien, m_samp, m_req, m_glvl, m_gp, m_sel;
    int m_upd, m_upd_d, m_cnt;

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_src = 0; m_div = 0; m_den = 0; m_vref = 0; m_hold = 0; m_ien = 0;
            m_samp = 0; m_req = 0; m_glvl = 0; m_gp = 0; m_sel = 0;
            m_upd = 0; m_upd_d = 0; m_cnt = 0;
        end else begin
            m_upd_d = m_upd;
            m_upd   = (m_hold != 0 && busy == 0) ? 1 : 0;
            if (m_cnt >= m_div) m_cnt = 0; else m_cnt = m_cnt + 1;
            m_req = 0;
            m_gp  = 0;
            if (we) begin
                if (be[3]) begin m_src = int'(wd[31:30]); m_div = int'(wd[29:24]); end
                if (be[2]) m_den = int'(wd[23]);
                if (be[1]) begin
                    m_vref = int'(wd[15:13]); m_hold = int'(wd[12]); m_ien = int'(wd[11]);
                    m_samp = int'(wd[9]); m_req = int'(wd[8]);
                end
                if (be[0]) begin m_glvl = int'(wd[7]); m_gp = int'(wd[6]); m_sel = int'(wd[5:0]); end
            end
        end
        live = 1;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    function automatic logic [31:0] model_word();
        logic [31:0] w;
        w = '0;
        w[31:30] = 2'(m_src); w[29:24] = 6'(m_div); w[23] = 1'(m_den);
        w[15:13] = 3'(m_vref); w[12] = 1'(m_hold); w[11] = 1'(m_ien);
        w[10] = 1'(m_upd); w[9] = 1'(m_samp); w[8] = 1'(m_req);
        w[7] = 1'(m_glvl); w[6] = 1'(m_gp); w[5:0] = 6'(m_sel);
        return w;
    endfunction

    // Per-cycle comparison
    always @(negedge clk) begin
        if (live) begin
            automatic bit open_g = (m_den != 0) && (m_hold == 0);
            chk("R2 read word", rdata, model_word());
            chk("R3/R11 conv_req", {31'd0, conv_req},
                {31'd0, 1'(open_g && m_req != 0 && m_sel != 63)});
            if (conv_req) chk("R3 conv_idx", {26'd0, conv_idx}, 32'(m_sel));
            chk("R4 gsw_pulse", {31'd0, gsw_pulse}, {31'd0, 1'(open_g && m_gp != 0)});
            chk("R4 gsw_level", {31'd0, gsw_level}, {31'd0, 1'(open_g && m_glvl != 0)});
            chk("R5 hw_trig_fire", {31'd0, hw_fire}, {31'd0, 1'(open_g && hw_in)});
            chk("R8 sample_force", {31'd0, samp}, {31'd0, 1'(m_samp)});
            chk("R9 ctl_clk_en", {31'd0, ctl_en}, {31'd0, 1'(m_cnt >= m_div)});
            chk("R7 upd_irq", {31'd0, irq},
                {31'd0, 1'(m_upd != 0 && m_upd_d == 0 && m_ien != 0)});
        end
    end

    task automatic wr(input logic [3:0] b, input logic [31:0] d);
        @(posedge clk); #2;
        we = 1'b1; be = b; wd = d;
        @(posedge clk); #2;
        we = 1'b0; be = '0; wd = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #2;
    endtask

    // Watchdog
    initial begin
        #80000;
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int en_cnt;
        idle(3);
        @(negedge clk);
        chk("R1 reset word", rdata, 32'd0);
        chk("R1 reset outputs", {26'd0, conv_req, gsw_pulse, gsw_level, hw_fire, samp, irq}, 32'd0);
        rst = 1'b0;
        idle(2);

        // R2: byte-enable writes
        wr(4'b0100, 32'h0080_0000);
        @(negedge clk); chk("R2 dig_en", {31'd0, rdata[23]}, 32'd1);
        wr(4'b1000, 32'h8300_0000);
        @(negedge clk); chk("R2 top byte", {24'd0, rdata[31:24]}, 32'h83);

        // R9: divide by 4
        idle(1);
        en_cnt = 0;
        for (int i = 0; i < 16; i++) begin @(negedge clk); if (ctl_en) en_cnt++; end
        chk("R9 div by 4 count", 32'(en_cnt), 32'd4);

        // R3: single request, input 5
        wr(4'b0011, 32'h0000_0105);
        @(negedge clk);
        chk("R3 req pulse", {31'd0, conv_req}, 32'd1);
        chk("R3 req idx", {26'd0, conv_idx}, 32'd5);
        @(negedge clk);
        chk("R3 req cleared", {31'd0, conv_req | rdata[8]}, 32'd0);

        // R11: reserved index dropped
        wr(4'b0011, 32'h0000_013F);
        @(negedge clk); chk("R11 reserved dropped", {31'd0, conv_req}, 32'd0);
        @(negedge clk); chk("R11 bit cleared", {31'd0, rdata[8]}, 32'd0);

        // R4: pulse and level
        wr(4'b0001, 32'h0000_0042);
        @(negedge clk); chk("R4 pulse high", {31'd0, gsw_pulse}, 32'd1);
        @(negedge clk); chk("R4 pulse gone", {31'd0, gsw_pulse}, 32'd0);
        wr(4'b0001, 32'h0000_0082);
        idle(5);
        @(negedge clk); chk("R4 level held", {31'd0, gsw_level}, 32'd1);
        wr(4'b0001, 32'h0000_0002);
        @(negedge clk); chk("R4 level cleared", {31'd0, gsw_level}, 32'd0);

        // R5: hardware trigger passes when open
        hw_in = 1'b1;
        @(negedge clk); chk("R5 hw open", {31'd0, hw_fire}, 32'd1);
        #6; hw_in = 1'b0;

        // R6/R7: hold with a converter busy, then idle
        busy = 2'b01;
        wr(4'b0010, 32'h0000_1800);
        idle(3);
        @(negedge clk); chk("R6 busy keeps not-ready", {31'd0, rdata[10]}, 32'd0);
        hw_in = 1'b1;
        @(negedge clk); chk("R5 hw blocked", {31'd0, hw_fire}, 32'd0);
        #6; hw_in = 1'b0;
        busy = 2'b00;
        @(posedge clk); #2;
        @(negedge clk);
        chk("R6 ready set", {31'd0, rdata[10]}, 32'd1);
        chk("R7 irq pulse", {31'd0, irq}, 32'd1);
        @(negedge clk); chk("R7 irq one cycle", {31'd0, irq}, 32'd0);

        // R5: request while held is dropped; bit 10 written 0 has no effect
        wr(4'b0011, 32'h0000_1903);
        @(negedge clk);
        chk("R5 held request dropped", {31'd0, conv_req}, 32'd0);
        chk("R6 write ignored", {31'd0, rdata[10]}, 32'd1);
        @(negedge clk); chk("R5 held bit cleared", {31'd0, rdata[8]}, 32'd0);

        // Release hold; writing 1 to bit 10 still reads 0
        wr(4'b0010, 32'h0000_0400);
        idle(2);
        @(negedge clk); chk("R6 ready off", {31'd0, rdata[10]}, 32'd0);

        // R7: interrupt disabled gives no pulse
        wr(4'b0010, 32'h0000_1000);
        idle(3);
        @(negedge clk); chk("R7 no irq when disabled", {31'd0, irq}, 32'd0);
        wr(4'b0010, 32'h0000_0000);

        // R10: digital disable
        wr(4'b0100, 32'h0000_0000);
        wr(4'b0011, 32'h0000_01C4);
        @(negedge clk);
        chk("R10 no triggers", {29'd0, conv_req, gsw_pulse, gsw_level}, 32'd0);
        @(negedge clk);
        chk("R10 self clear", {30'd0, rdata[8], rdata[6]}, 32'd0);
        wr(4'b0001, 32'h0000_0004);
        wr(4'b0100, 32'h0080_0000);

        // R8: manual sample holds
        wr(4'b0010, 32'h0000_0200);
        idle(6);
        @(negedge clk); chk("R8 sample held", {31'd0, samp}, 32'd1);
        wr(4'b0010, 32'h0000_0000);
        @(negedge clk); chk("R8 sample off", {31'd0, samp}, 32'd0);

        // R9: divider 0 gives every cycle
        wr(4'b1000, 32'h0000_0000);
        en_cnt = 0;
        for (int i = 0; i < 8; i++) begin @(negedge clk); if (ctl_en) en_cnt++; end
        chk("R9 undivided", 32'(en_cnt), 32'd8);

        idle(4);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule